// File: doc/BRIEF.md
# Priority Port-Pin Crossbar

This block decides which on-chip peripheral signal drives each of sixteen general-purpose port pins. The pins form two 8-bit ports. Software-style configuration inputs choose which peripherals take part: per-peripheral enable bits, a 4-wire select for the SPI, and a 2-bit count of PCA capture/compare outputs. Two 8-bit skip masks reserve pins for special uses such as crystal, analog or conversion-start functions. The crossbar never assigns those special uses itself.

The enabled signals are handed out one at a time in a fixed priority order. Each one takes the lowest-numbered pin that is neither masked nor already taken. A later-priority signal therefore moves whenever an earlier one is switched on or a pin is masked. The block is not a fixed per-pin multiplexer. A signal that finds no free pin is reported as unrouted.

The configuration is captured in registers on the clock. The pin map is derived combinationally from the registered copy. For every pin the block gives a select code. For every signal it gives a routed flag and the pin index it landed on.

Top module: `pin_crossbar`

## Requirements
- R1: While `rst_n` is low, every pin code, every routed flag and every pin index is zero, whatever the configuration inputs are.
- R2: Pin index p runs 0..7 for port 0 bits 0..7 and 8..15 for port 1 bits 0..7. Enabled signals are placed in the order UART TX (0), UART RX (1), SPI SCK (2), SPI MISO (3), SPI MOSI (4), SPI NSS (5), LIN TX (6), LIN RX (7), comparator synchronous output (8), comparator asynchronous output (9), system clock out (10), PCA CEX0 (11), CEX1 (12), CEX2 (13), PCA ECI (14), timer 0 input (15), timer 1 input (16). Each takes the lowest pin index that is neither masked nor taken by an earlier signal, and reports that index on its `sig_pin_idx` field.
- R3: A set bit n of `skip_mask_p0` (pin n), or of `skip_mask_p1` (pin 8+n), keeps that pin from being assigned. The pin reports code 0, and placement continues at the next pin.
- R4: NSS (signal 5) is placed only when both `spi_en` and `spi_four_wire` are set.
- R5: `uart_en` requests signals 0 and 1. `spi_en` requests 2, 3 and 4. `lin_en` requests 6 and 7. `pca_cex_count` = k requests CEX0 up to CEX(k-1), where k = 3 requests all three. Every other signal has its own enable.
- R6: A requested signal for which no free pin remains is left unrouted: its flag is 0 and its pin index is 0. Signals that are not requested behave the same way.
- R7: Pin code 0 means general-purpose I/O, used for unassigned and masked pins. Code s+1 (1..17) means signal s drives the pin.
- R8: A configuration change shows on the outputs only after the next rising clock edge. Until that edge the outputs keep the map of the previous configuration.
- R9: For every routed signal s, the code of the pin named by its index equals s+1. The number of non-zero pin codes equals the number of routed flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uart_en | input | 1 | Request UART TX and RX |
| spi_en | input | 1 | Request SCK, MISO, MOSI |
| spi_four_wire | input | 1 | Also request NSS when SPI is on |
| lin_en | input | 1 | Request LIN TX and RX |
| cmp_sync_en | input | 1 | Request comparator synchronous output |
| cmp_async_en | input | 1 | Request comparator asynchronous output |
| clkout_en | input | 1 | Request system clock output |
| pca_cex_count | input | 2 | Number of CEX outputs requested (0..3) |
| pca_eci_en | input | 1 | Request PCA external clock input |
| tmr0_in_en | input | 1 | Request timer 0 input |
| tmr1_in_en | input | 1 | Request timer 1 input |
| skip_mask_p0 | input | 8 | Reserved pins of port 0 |
| skip_mask_p1 | input | 8 | Reserved pins of port 1 |
| pin_sel | output | 80 | Per-pin 5-bit select code, pin p in bits [5p+4:5p] |
| sig_routed | output | 17 | Per-signal routed flag |
| sig_pin_idx | output | 68 | Per-signal 4-bit pin index, signal s in bits [4s+3:4s] |

## Verification
The bench runs three kinds of configuration. The first enables every signal, so the seventeenth finds no pin. A design that wrapped around or dropped the wrong signal would put timer 1 on a pin, or leave a gap. The second uses masks that fence off pins in the middle of a run and at the very end. A decoder that ignored a mask bit, or skipped one pin too many, would shift every later signal by one. The third toggles 4-wire mode and the CEX count, and changes inputs just before an edge. These catch NSS leaking out in 3-wire mode, off-by-one CEX enables, and a map that follows the raw inputs without waiting for the register.

// File: rtl/pxb_pkg.sv
package pxb_pkg;

   // Signal slots in placement priority; the order is behaviour.
   localparam int SIG_U_TX    = 0;
   localparam int SIG_U_RX    = 1;
   localparam int SIG_SCK     = 2;
   localparam int SIG_MISO    = 3;
   localparam int SIG_MOSI    = 4;
   localparam int SIG_NSS     = 5;
   localparam int SIG_LIN_TX  = 6;
   localparam int SIG_LIN_RX  = 7;
   localparam int SIG_CMP_S   = 8;
   localparam int SIG_CMP_A   = 9;
   localparam int SIG_CLKO    = 10;
   localparam int SIG_CEX0    = 11;
   localparam int MAX_CEX     = 3;
   localparam int SIG_ECI     = SIG_CEX0 + MAX_CEX;
   localparam int SIG_T0      = SIG_ECI + 1;
   localparam int SIG_T1      = SIG_T0 + 1;
   localparam int NUM_SIGS    = SIG_T1 + 1;

   localparam int CEX_CNT_W   = $clog2(MAX_CEX + 1);
   localparam int CODE_W      = $clog2(NUM_SIGS + 1);

   typedef struct packed {
      logic                 uart;
      logic                 spi;
      logic                 spi4;
      logic                 lin;
      logic                 cmp_s;
      logic                 cmp_a;
      logic                 clko;
      logic [CEX_CNT_W-1:0] cex_cnt;
      logic                 eci;
      logic                 t0;
      logic                 t1;
   } pxb_cfg_t;

endpackage

// File: rtl/pxb_cfg_reg.sv
module pxb_cfg_reg #(
   parameter int NUM_PINS = 16
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  pxb_pkg::pxb_cfg_t     cfg_d,
   input  logic [NUM_PINS-1:0]   skip_d,
   output pxb_pkg::pxb_cfg_t     cfg_q,
   output logic [NUM_PINS-1:0]   skip_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q  <= '0;
         skip_q <= '0;
      end else begin
         cfg_q  <= cfg_d;
         skip_q <= skip_d;
      end
   end

endmodule

// File: rtl/pxb_req_decode.sv
module pxb_req_decode
   import pxb_pkg::*;
(
   input  pxb_cfg_t              cfg,
   output logic [NUM_SIGS-1:0]   req
);

   always_comb begin
      req               = '0;
      req[SIG_U_TX]     = cfg.uart;
      req[SIG_U_RX]     = cfg.uart;
      req[SIG_SCK]      = cfg.spi;
      req[SIG_MISO]     = cfg.spi;
      req[SIG_MOSI]     = cfg.spi;
      req[SIG_NSS]      = cfg.spi & cfg.spi4;
      req[SIG_LIN_TX]   = cfg.lin;
      req[SIG_LIN_RX]   = cfg.lin;
      req[SIG_CMP_S]    = cfg.cmp_s;
      req[SIG_CMP_A]    = cfg.cmp_a;
      req[SIG_CLKO]     = cfg.clko;
      req[SIG_ECI]      = cfg.eci;
      req[SIG_T0]       = cfg.t0;
      req[SIG_T1]       = cfg.t1;
      for (int i = 0; i < MAX_CEX; i++) begin
         req[SIG_CEX0 + i] = (int'(cfg.cex_cnt) > i);
      end
   end

endmodule

// File: rtl/pxb_lowest_free.sv
module pxb_lowest_free #(
   parameter int W      = 16,
   parameter int IDX_W  = $clog2(W),
   parameter int IMPL   = 0
) (
   input  logic [W-1:0]      free_vec,
   output logic [W-1:0]      pick_oh,
   output logic [IDX_W-1:0]  pick_idx,
   output logic              found
);

   generate
      if (IMPL == 0) begin : g_arith
         assign pick_oh = free_vec & (~free_vec + W'(1));
      end else begin : g_scan
         always_comb begin
            pick_oh = '0;
            for (int i = W - 1; i >= 0; i--) begin
               if (free_vec[i]) begin
                  pick_oh    = '0;
                  pick_oh[i] = 1'b1;
               end
            end
         end
      end
   endgenerate

   assign found = |free_vec;

   always_comb begin
      pick_idx = '0;
      for (int i = 0; i < W; i++) begin
         if (pick_oh[i]) pick_idx = IDX_W'(i);
      end
   end

endmodule

// File: rtl/pxb_assign.sv
module pxb_assign #(
   parameter int NUM_PINS  = 16,
   parameter int NUM_SIGS  = 17,
   parameter int CODE_W    = 5,
   parameter int IDX_W     = 4,
   parameter int PICK_IMPL = 0
) (
   input  logic [NUM_SIGS-1:0]           req,
   input  logic [NUM_PINS-1:0]           skip,
   output logic [NUM_PINS*CODE_W-1:0]    pin_code,
   output logic [NUM_SIGS-1:0]           routed,
   output logic [NUM_SIGS*IDX_W-1:0]     pin_idx
);

   logic [NUM_PINS-1:0] taken [NUM_SIGS+1];
   logic [NUM_PINS-1:0] grant [NUM_SIGS];

   assign taken[0] = skip;

   generate
      for (genvar s = 0; s < NUM_SIGS; s++) begin : g_sig
         logic [NUM_PINS-1:0] oh;
         logic [IDX_W-1:0]    idx;
         logic                any_free;
         logic                win;

         pxb_lowest_free #(
            .W     (NUM_PINS),
            .IDX_W (IDX_W),
            .IMPL  (PICK_IMPL)
         ) u_pick (
            .free_vec (~taken[s]),
            .pick_oh  (oh),
            .pick_idx (idx),
            .found    (any_free)
         );

         assign win          = req[s] & any_free;
         assign grant[s]     = win ? oh : '0;
         assign taken[s+1]   = taken[s] | grant[s];
         assign routed[s]    = win;
         assign pin_idx[s*IDX_W +: IDX_W] = win ? idx : '0;
      end

      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
         logic [CODE_W-1:0] code_p;
         always_comb begin
            code_p = '0;
            for (int s = 0; s < NUM_SIGS; s++) begin
               if (grant[s][p]) code_p = code_p | CODE_W'(s + 1);
            end
         end
         assign pin_code[p*CODE_W +: CODE_W] = code_p;
      end
   endgenerate

endmodule

// File: rtl/pin_crossbar.sv
module pin_crossbar
   import pxb_pkg::*;
#(
   parameter int PORT_W    = 8,
   parameter int NUM_PORTS = 2,
   parameter int PICK_IMPL = 0,
   localparam int NUM_PINS = PORT_W * NUM_PORTS,
   localparam int IDX_W    = $clog2(NUM_PINS)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          uart_en,
   input  logic                          spi_en,
   input  logic                          spi_four_wire,
   input  logic                          lin_en,
   input  logic                          cmp_sync_en,
   input  logic                          cmp_async_en,
   input  logic                          clkout_en,
   input  logic [CEX_CNT_W-1:0]          pca_cex_count,
   input  logic                          pca_eci_en,
   input  logic                          tmr0_in_en,
   input  logic                          tmr1_in_en,
   input  logic [PORT_W-1:0]             skip_mask_p0,
   input  logic [PORT_W-1:0]             skip_mask_p1,
   output logic [NUM_PINS*CODE_W-1:0]    pin_sel,
   output logic [NUM_SIGS-1:0]           sig_routed,
   output logic [NUM_SIGS*IDX_W-1:0]     sig_pin_idx
);

   if (NUM_PORTS != 2) begin : g_bad_ports
      $fatal(1, "pin_crossbar: exactly two ports are supported");
   end
   if (PORT_W < 1 || PORT_W > 32) begin : g_bad_width
      $fatal(1, "pin_crossbar: PORT_W out of range");
   end
   if (PICK_IMPL != 0 && PICK_IMPL != 1) begin : g_bad_impl
      $fatal(1, "pin_crossbar: PICK_IMPL must be 0 or 1");
   end

   pxb_cfg_t             cfg_d;
   pxb_cfg_t             cfg_q;
   logic [NUM_PINS-1:0]  skip_q;
   logic [NUM_SIGS-1:0]  req;

   always_comb begin
      cfg_d.uart    = uart_en;
      cfg_d.spi     = spi_en;
      cfg_d.spi4    = spi_four_wire;
      cfg_d.lin     = lin_en;
      cfg_d.cmp_s   = cmp_sync_en;
      cfg_d.cmp_a   = cmp_async_en;
      cfg_d.clko    = clkout_en;
      cfg_d.cex_cnt = pca_cex_count;
      cfg_d.eci     = pca_eci_en;
      cfg_d.t0      = tmr0_in_en;
      cfg_d.t1      = tmr1_in_en;
   end

   pxb_cfg_reg #(.NUM_PINS(NUM_PINS)) u_cfg (
      .clk    (clk),
      .rst_n  (rst_n),
      .cfg_d  (cfg_d),
      .skip_d ({skip_mask_p1, skip_mask_p0}),
      .cfg_q  (cfg_q),
      .skip_q (skip_q)
   );

   pxb_req_decode u_dec (
      .cfg (cfg_q),
      .req (req)
   );

   pxb_assign #(
      .NUM_PINS  (NUM_PINS),
      .NUM_SIGS  (NUM_SIGS),
      .CODE_W    (CODE_W),
      .IDX_W     (IDX_W),
      .PICK_IMPL (PICK_IMPL)
   ) u_asg (
      .req      (req),
      .skip     (skip_q),
      .pin_code (pin_sel),
      .routed   (sig_routed),
      .pin_idx  (sig_pin_idx)
   );

endmodule

// File: rtl/pxb_checker.sv
module pxb_checker
   import pxb_pkg::*;
#(
   parameter int NUM_PINS = 16,
   parameter int IDX_W    = 4
) (
   input logic                          clk,
   input logic                          rst_n,
   input pxb_cfg_t                      cfg_q,
   input logic [NUM_PINS-1:0]           skip_q,
   input logic [NUM_PINS*CODE_W-1:0]    pin_sel,
   input logic [NUM_SIGS-1:0]           sig_routed,
   input logic [NUM_SIGS*IDX_W-1:0]     sig_pin_idx
);

   function automatic int used_pins(input logic [NUM_PINS*CODE_W-1:0] v);
      int n = 0;
      for (int p = 0; p < NUM_PINS; p++) begin
         if (v[p*CODE_W +: CODE_W] != '0) n++;
      end
      return n;
   endfunction

   always @(negedge clk) begin
      if (!rst_n) begin
         p_reset_idle_r1: assert (pin_sel == '0 && sig_routed == '0 && sig_pin_idx == '0)
            else $error("reset state not idle");
      end
   end

   p_nss_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sig_routed[SIG_NSS] |-> (cfg_q.spi && cfg_q.spi4));

   p_one_to_one_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(sig_routed) == used_pins(pin_sel));

   generate
      for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin_chk
         p_skip_gpio_r3: assert property (@(posedge clk) disable iff (!rst_n)
            skip_q[p] |-> (pin_sel[p*CODE_W +: CODE_W] == '0));
         p_code_range_r7: assert property (@(posedge clk) disable iff (!rst_n)
            int'(pin_sel[p*CODE_W +: CODE_W]) <= NUM_SIGS);
      end
      for (genvar s = 0; s < NUM_SIGS; s++) begin : g_sig_chk
         p_pin_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
            sig_routed[s] |->
               (int'(pin_sel[int'(sig_pin_idx[s*IDX_W +: IDX_W])*CODE_W +: CODE_W]) == s + 1));
         p_unrouted_idx_r6: assert property (@(posedge clk) disable iff (!rst_n)
            !sig_routed[s] |-> (sig_pin_idx[s*IDX_W +: IDX_W] == '0));
      end
   endgenerate

endmodule

bind pin_crossbar pxb_checker #(
   .NUM_PINS (NUM_PINS),
   .IDX_W    (IDX_W)
) u_pxb_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .cfg_q       (cfg_q),
   .skip_q      (skip_q),
   .pin_sel     (pin_sel),
   .sig_routed  (sig_routed),
   .sig_pin_idx (sig_pin_idx)
);

// File: tb/test_pin_crossbar.sv
`timescale 1ns/1ps
module test_pin_crossbar;

   localparam int NP = 16;
   localparam int NS = 17;
   localparam int CW = 5;
   localparam int IW = 4;

   logic clk = 1'b0;
   logic rst_n;
   logic uart_en, spi_en, spi_four_wire, lin_en, cmp_sync_en, cmp_async_en;
   logic clkout_en, pca_eci_en, tmr0_in_en, tmr1_in_en;
   logic [1:0] pca_cex_count;
   logic [7:0] skip_mask_p0, skip_mask_p1;
   logic [NP*CW-1:0] pin_sel;
   logic [NS-1:0]    sig_routed;
   logic [NS*IW-1:0] sig_pin_idx;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   // configuration as captured by the design (model view)
   bit c_u, c_sp, c_s4, c_ln, c_cs, c_ca, c_ck, c_ec, c_a0, c_a1;
   bit [1:0] c_cx;
   bit [7:0] c_k0, c_k1;

   int exp_code [NP];
   bit exp_rt   [NS];
   bit exp_req  [NS];
   int exp_idx  [NS];
   logic [NP*CW-1:0] exp_sel_v;
   logic [NS-1:0]    exp_rt_v;
   logic [NS*IW-1:0] exp_idx_v;

   always #5 clk = ~clk;

   pin_crossbar i_pin_crossbar (
      .clk(clk), .rst_n(rst_n),
      .uart_en(uart_en), .spi_en(spi_en), .spi_four_wire(spi_four_wire),
      .lin_en(lin_en), .cmp_sync_en(cmp_sync_en), .cmp_async_en(cmp_async_en),
      .clkout_en(clkout_en), .pca_cex_count(pca_cex_count), .pca_eci_en(pca_eci_en),
      .tmr0_in_en(tmr0_in_en), .tmr1_in_en(tmr1_in_en),
      .skip_mask_p0(skip_mask_p0), .skip_mask_p1(skip_mask_p1),
      .pin_sel(pin_sel), .sig_routed(sig_routed), .sig_pin_idx(sig_pin_idx)
   );

   task automatic chk(input bit ok, input string tag, input string what,
                      input logic [95:0] act, input logic [95:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // behavioural model: a queue of free pins, popped in priority order
   function automatic void compute();
      int freeq[$];
      bit [15:0] sk;
      sk = {c_k1, c_k0};
      exp_req = '{default: 0};
      exp_req[0] = c_u;  exp_req[1] = c_u;
      exp_req[2] = c_sp; exp_req[3] = c_sp; exp_req[4] = c_sp;
      exp_req[5] = c_sp && c_s4;
      exp_req[6] = c_ln; exp_req[7] = c_ln;
      exp_req[8] = c_cs; exp_req[9] = c_ca; exp_req[10] = c_ck;
      exp_req[11] = (c_cx >= 1); exp_req[12] = (c_cx >= 2); exp_req[13] = (c_cx >= 3);
      exp_req[14] = c_ec; exp_req[15] = c_a0; exp_req[16] = c_a1;
      for (int p = 0; p < NP; p++) begin
         exp_code[p] = 0;
         if (!sk[p]) freeq.push_back(p);
      end
      for (int s = 0; s < NS; s++) begin
         exp_rt[s] = 0; exp_idx[s] = 0;
         if (exp_req[s] && freeq.size() > 0) begin
            int p;
            p = freeq.pop_front();
            exp_rt[s] = 1; exp_idx[s] = p; exp_code[p] = s + 1;
         end
      end
      for (int p = 0; p < NP; p++) exp_sel_v[p*CW +: CW] = CW'(exp_code[p]);
      for (int s = 0; s < NS; s++) begin
         exp_rt_v[s] = exp_rt[s];
         exp_idx_v[s*IW +: IW] = IW'(exp_idx[s]);
      end
   endfunction

   task automatic check_all();
      bit [15:0] sk;
      sk = {c_k1, c_k0};
      for (int p = 0; p < NP; p++) begin
         string tg;
         tg = sk[p] ? "R3" : (exp_code[p] == 0 ? "R7" : "R2");
         chk(int'(pin_sel[p*CW +: CW]) == exp_code[p], tg, $sformatf("pin %0d code", p),
             96'(pin_sel[p*CW +: CW]), 96'(exp_code[p]));
      end
      for (int s = 0; s < NS; s++) begin
         string tg;
         if (s == 5) tg = "R4";
         else if (exp_req[s] && !exp_rt[s]) tg = "R6";
         else tg = "R5";
         chk(sig_routed[s] == exp_rt[s], tg, $sformatf("signal %0d routed", s),
             96'(sig_routed[s]), 96'(exp_rt[s]));
         chk(int'(sig_pin_idx[s*IW +: IW]) == exp_idx[s], exp_rt[s] ? "R2" : "R6",
             $sformatf("signal %0d pin index", s), 96'(sig_pin_idx[s*IW +: IW]), 96'(exp_idx[s]));
         if (sig_routed[s]) begin
            int ap;
            ap = int'(sig_pin_idx[s*IW +: IW]);
            chk(int'(pin_sel[ap*CW +: CW]) == s + 1, "R9", $sformatf("signal %0d pin code", s),
                96'(pin_sel[ap*CW +: CW]), 96'(s + 1));
         end
      end
   endtask

   // called at a falling edge: drive, confirm hold, then check after the next edge
   task automatic apply(input bit u, sp, s4, ln, cs, ca, ck, input bit [1:0] cx,
                        input bit ec, a0, a1, input bit [7:0] k0, k1);
      uart_en = u; spi_en = sp; spi_four_wire = s4; lin_en = ln;
      cmp_sync_en = cs; cmp_async_en = ca; clkout_en = ck; pca_cex_count = cx;
      pca_eci_en = ec; tmr0_in_en = a0; tmr1_in_en = a1;
      skip_mask_p0 = k0; skip_mask_p1 = k1;
      #1;
      chk(pin_sel == exp_sel_v && sig_routed == exp_rt_v && sig_pin_idx == exp_idx_v,
          "R8", "outputs before edge", 96'(pin_sel), 96'(exp_sel_v));
      c_u = u; c_sp = sp; c_s4 = s4; c_ln = ln; c_cs = cs; c_ca = ca; c_ck = ck;
      c_cx = cx; c_ec = ec; c_a0 = a0; c_a1 = a1; c_k0 = k0; c_k1 = k1;
      @(negedge clk);
      compute();
      check_all();
   endtask

   initial begin : watchdog
      forever begin
         @(posedge clk);
         cycles++;
         if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
         end
      end
   end

   initial begin : stim
      rst_n = 1'b0;
      // drive a busy configuration during reset: outputs must stay idle
      uart_en = 1; spi_en = 1; spi_four_wire = 1; lin_en = 1; cmp_sync_en = 1;
      cmp_async_en = 1; clkout_en = 1; pca_cex_count = 3; pca_eci_en = 1;
      tmr0_in_en = 1; tmr1_in_en = 1; skip_mask_p0 = 0; skip_mask_p1 = 0;
      c_u = 0; c_sp = 0; c_s4 = 0; c_ln = 0; c_cs = 0; c_ca = 0; c_ck = 0;
      c_cx = 0; c_ec = 0; c_a0 = 0; c_a1 = 0; c_k0 = 0; c_k1 = 0;
      compute();
      repeat (3) @(negedge clk);
      chk(pin_sel == '0, "R1", "pin codes in reset", 96'(pin_sel), 96'(0));
      chk(sig_routed == '0, "R1", "routed flags in reset", 96'(sig_routed), 96'(0));
      chk(sig_pin_idx == '0, "R1", "pin indices in reset", 96'(sig_pin_idx), 96'(0));
      uart_en = 0; spi_en = 0; spi_four_wire = 0; lin_en = 0; cmp_sync_en = 0;
      cmp_async_en = 0; clkout_en = 0; pca_cex_count = 0; pca_eci_en = 0;
      tmr0_in_en = 0; tmr1_in_en = 0;
      rst_n = 1'b1;
      @(negedge clk);
      check_all();

      // R6: all seventeen requested, timer 1 runs out of pins
      apply(1,1,1,1,1,1,1,2'd3,1,1,1, 8'h00, 8'h00);
      // R4: 3-wire SPI frees a pin, timer 1 lands on pin 15
      apply(1,1,0,1,1,1,1,2'd3,1,1,1, 8'h00, 8'h00);
      // R3: crystal pins 8,9 reserved
      apply(1,1,1,1,1,1,1,2'd3,1,1,1, 8'h00, 8'h03);
      // R3: whole port 0 reserved, SPI starts at pin 8
      apply(0,1,1,0,0,0,0,2'd0,0,0,0, 8'hFF, 8'h00);
      // R3: UART pins reserved, SPI moved up
      apply(1,1,1,0,0,0,0,2'd0,0,0,0, 8'h03, 8'h00);
      // R5: CEX counts 0..3
      for (int k = 0; k < 4; k++) apply(0,0,0,0,0,0,0,2'(k),1,0,0, 8'h00, 8'h00);
      // R6: every pin reserved
      apply(1,1,1,1,1,1,1,2'd3,1,1,1, 8'hFF, 8'hFF);
      // R6: one free pin at the very end
      apply(0,0,0,1,0,0,0,2'd0,0,0,0, 8'hFF, 8'h7F);
      // R7: nothing enabled
      apply(0,0,0,0,0,0,0,2'd0,0,0,0, 8'h00, 8'h00);

      for (int i = 0; i < 400; i++) begin
         apply(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), 1'($urandom),
               1'($urandom), 8'($urandom & $urandom), 8'($urandom & $urandom));
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule